// File: doc/BRIEF.md
# Viterbi Traceback Address Generator

This block walks backwards through the survivor memory of a folded Viterbi decoder whose constraint length can be switched between 7 and 10. The survivor memory is 4096 words of 8 bits; a trellis position is held as an iteration number, a column (the low part of the word address) and a row (the bit index inside the word). Given a starting position, normally the best state found by a separate unit, the block reads one survivor bit per step and works out the previous position from a fixed rearrangement of the column and row bits. This rearrangement uses only two XOR gates and changes with the constraint length.

A run is described by a discard count D and an output count N. The block visits D+N-1 positions, one every two clocks. The first D-1 positions only move the walk along. Each of the last N positions yields one decoded bit, and these bits leave in reverse time order with a one-cycle strobe. Anything that reorders them lies outside the block, and so do the writes into the survivor memory.

Top module: `tbk_addr_gen`

## Requirements
- R1: After reset, `busy`, `mem_rd` and `dec_valid` are 0.
- R2: With length code k (0..3 for constraint lengths 7..10) the column field is 3+k bits wide and the iteration field is the 9-k bits above it. `mem_addr` = iteration shifted left by 3+k, OR the column. `start_addr` is split the same way.
- R3: For k=0 the next row is {R1^C1, V, C2} and the next column is {C1, C0, R2^C2}. Example: R=101, C=100 and V=1 give R=011 and C=000.
- R4: For k=1..3, with t=2+k the top column bit, the next row is {R1^C[t-1], V, C[t]} and the next column is {C[t-1:0], R2^C[t]}.
- R5: The iteration field decreases by one on every step and wraps from 0 to its all-ones value inside its 9-k bits.
- R6: Each step lasts exactly two clocks. `mem_rd` is high in the first clock and low in the second. `busy` stays high for exactly 2*(D+N-1) clocks.
- R7: Visited positions 0..D-2 produce no output. Positions D-1..D+N-2 each produce one decoded bit, equal to row bit 0 of that position, in visiting order.
- R8: Exactly N `dec_valid` pulses are produced per run, and `busy` falls in the same cycle as the last one.
- R9: `start` is ignored while `busy` is high. The run in progress continues unchanged.
- R10: The survivor bit V is bit R of the word read in the step's first clock (bit 0 is the LSB). The memory returns read data one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_k | input | 2 | Constraint length code, sampled on start |
| start | input | 1 | Start a traceback run when idle |
| start_addr | input | 12 | Starting iteration and column, packed as in R2 |
| start_row | input | 3 | Starting row |
| depth | input | CNT_W | Discard count D (at least 1) |
| nout | input | CNT_W | Output count N (at least 1) |
| mem_addr | output | 12 | Survivor memory read address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Survivor word, valid one clock after the address |
| busy | output | 1 | Run in progress |
| dec_valid | output | 1 | Decoded bit strobe |
| dec_bit | output | 1 | Decoded bit |

## Verification
The bench plants a random chain of survivor bits along a path that it computes itself, so a wrong XOR term or a wrong column width sends the walk off the path and corrupts the address stream and the later decoded bits. The iteration wrap at length 10 is exercised by starting near zero. A design that decremented across the whole address would land in the wrong column. The boundary run with D=N=1 exposes off-by-one errors in the discard count and in the last-step detection, which would show up as a wrong busy length or a missing or extra strobe. A second start pulse during a run checks that a block which reloaded would jump to a different address.

// File: rtl/tbk_pkg.sv
package tbk_pkg;
  localparam int ADDR_W = 12;
  localparam int ROW_W  = 3;
  localparam int WORD_W = 8;
  localparam int COL_MAXW  = 6;
  localparam int ITER_MAXW = 9;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} tbk_state_t;

  function automatic logic [COL_MAXW-1:0] col_mask(input logic [1:0] k);
    return COL_MAXW'((7'd1 << (3'd3 + 3'(k))) - 7'd1);
  endfunction

  function automatic logic [ITER_MAXW-1:0] iter_mask(input logic [1:0] k);
    return ITER_MAXW'((10'd1 << (4'd9 - 4'(k))) - 10'd1);
  endfunction

  function automatic logic [ADDR_W-1:0] pack_addr(input logic [1:0] k,
      input logic [ITER_MAXW-1:0] it, input logic [COL_MAXW-1:0] c);
    logic [ADDR_W-1:0] hi;
    hi = {3'd0, it & iter_mask(k)} << (3'd3 + 3'(k));
    return hi | {6'd0, c & col_mask(k)};
  endfunction

  function automatic logic [ITER_MAXW-1:0] unpack_iter(input logic [1:0] k,
      input logic [ADDR_W-1:0] a);
    return ITER_MAXW'(a >> (3'd3 + 3'(k))) & iter_mask(k);
  endfunction

  function automatic logic [COL_MAXW-1:0] unpack_col(input logic [1:0] k,
      input logic [ADDR_W-1:0] a);
    return a[COL_MAXW-1:0] & col_mask(k);
  endfunction

  function automatic logic col_top(input logic [1:0] k, input logic [COL_MAXW-1:0] c);
    return 1'(c >> (3'd2 + 3'(k)));
  endfunction

  function automatic logic col_sub(input logic [1:0] k, input logic [COL_MAXW-1:0] c);
    return 1'(c >> (3'd1 + 3'(k)));
  endfunction

  function automatic logic [ROW_W-1:0] next_row(input logic [1:0] k,
      input logic [ROW_W-1:0] r, input logic [COL_MAXW-1:0] c, input logic v);
    return {r[1] ^ col_sub(k, c), v, col_top(k, c)};
  endfunction

  function automatic logic [COL_MAXW-1:0] next_col(input logic [1:0] k,
      input logic [ROW_W-1:0] r, input logic [COL_MAXW-1:0] c);
    logic [COL_MAXW-1:0] sh;
    sh = {c[COL_MAXW-2:0], r[2] ^ col_top(k, c)};
    return sh & col_mask(k);
  endfunction

  function automatic logic [ITER_MAXW-1:0] prev_iter(input logic [1:0] k,
      input logic [ITER_MAXW-1:0] it);
    return (it - 1'b1) & iter_mask(k);
  endfunction
endpackage

// File: rtl/tbk_position.sv
module tbk_position
  import tbk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  step,
  input  logic [1:0]            cfg_k,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic [ROW_W-1:0]      start_row,
  input  logic [WORD_W-1:0]     word,
  output logic [1:0]            k_q,
  output logic [ITER_MAXW-1:0]  iter,
  output logic [COL_MAXW-1:0]   col,
  output logic [ROW_W-1:0]      row,
  output logic                  v_bit,
  output logic [ADDR_W-1:0]     addr
);
  assign v_bit = word[row];
  assign addr  = pack_addr(k_q, iter, col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q  <= '0;
      iter <= '0;
      col  <= '0;
      row  <= '0;
    end else if (load) begin
      k_q  <= cfg_k;
      iter <= unpack_iter(cfg_k, start_addr);
      col  <= unpack_col(cfg_k, start_addr);
      row  <= start_row;
    end else if (step) begin
      iter <= prev_iter(k_q, iter);
      col  <= next_col(k_q, row, col);
      row  <= next_row(k_q, row, col, v_bit);
    end
  end

  // R10
  v_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> row[1] == $past(v_bit));
endmodule

// File: rtl/tbk_seq.sv
module tbk_seq
  import tbk_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] depth,
  input  logic [CNT_W-1:0] nout,
  output logic             load,
  output logic             rd,
  output logic             step,
  output logic             emit,
  output logic             last,
  output logic             busy,
  output logic [CNT_W:0]   step_cnt
);
  tbk_state_t st;
  logic [CNT_W-1:0] d_q, n_q;
  logic [CNT_W:0]   last_idx;

  assign last_idx = {1'b0, d_q} + {1'b0, n_q} - (CNT_W+1)'(2);
  assign load = (st == S_IDLE) && start;
  assign rd   = (st == S_ADDR);
  assign step = (st == S_DATA);
  assign busy = (st != S_IDLE);
  assign last = step && (step_cnt == last_idx);
  assign emit = step && ((step_cnt + 1'b1) >= {1'b0, d_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      d_q      <= '0;
      n_q      <= '0;
      step_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_ADDR;
          d_q      <= depth;
          n_q      <= nout;
          step_cnt <= '0;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: begin
          st       <= last ? S_IDLE : S_ADDR;
          step_cnt <= step_cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> step && !rd);
  // R9
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> busy && (step_cnt >= $past(step_cnt)));
endmodule

// File: rtl/tbk_emit.sv
module tbk_emit (
  input  logic clk,
  input  logic rst_n,
  input  logic emit,
  input  logic bit_in,
  output logic dec_valid,
  output logic dec_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_bit   <= 1'b0;
    end else begin
      dec_valid <= emit;
      if (emit) dec_bit <= bit_in;
    end
  end
endmodule

// File: rtl/tbk_addr_gen.sv
module tbk_addr_gen
  import tbk_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_k,
  input  logic              start,
  input  logic [11:0]       start_addr,
  input  logic [2:0]        start_row,
  input  logic [CNT_W-1:0]  depth,
  input  logic [CNT_W-1:0]  nout,
  output logic [11:0]       mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              dec_valid,
  output logic              dec_bit
);
  logic load, step, emit, last;
  logic [CNT_W:0] step_cnt;
  logic [1:0] k_q;
  logic [ITER_MAXW-1:0] iter;
  logic [COL_MAXW-1:0] col;
  logic [ROW_W-1:0] row;
  logic v_bit;

  tbk_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .depth(depth), .nout(nout),
    .load(load), .rd(mem_rd), .step(step), .emit(emit), .last(last),
    .busy(busy), .step_cnt(step_cnt)
  );

  tbk_position u_pos (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .cfg_k(cfg_k),
    .start_addr(start_addr), .start_row(start_row), .word(mem_rdata),
    .k_q(k_q), .iter(iter), .col(col), .row(row), .v_bit(v_bit),
    .addr(mem_addr)
  );

  tbk_emit u_emit (
    .clk(clk), .rst_n(rst_n), .emit(emit), .bit_in(row[0]),
    .dec_valid(dec_valid), .dec_bit(dec_bit)
  );

  // R5
  iter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> iter == (($past(iter) - 1'b1) & iter_mask(k_q)));
  // R8
  valid_follows_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(step));
  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && emit) |=> dec_valid && !busy);
endmodule

// File: tb/tb_tbk_addr_gen.sv
module tb_tbk_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 7;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_k = 0;
  logic start = 0;
  logic [11:0] start_addr = 0;
  logic [2:0] start_row = 0;
  logic [CNT_W-1:0] depth = 1, nout = 1;
  logic [11:0] mem_addr;
  logic mem_rd, busy, dec_valid, dec_bit;
  logic [7:0] mem_rdata;
  logic [7:0] mem [4096];

  int checks = 0, failures = 0;
  int seed = 32'h1234_5678;
  logic [11:0] exp_addr [256];
  logic        exp_bit  [256];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) mem_rdata <= mem[mem_addr];

  tbk_addr_gen #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_k(cfg_k), .start(start),
    .start_addr(start_addr), .start_row(start_row), .depth(depth), .nout(nout),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .busy(busy), .dec_valid(dec_valid), .dec_bit(dec_bit)
  );

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff_ffff;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench restatement of the walk: one predecessor per step
  task automatic walk(int k, inout int it, inout int c, inout int r, input int v);
    int w, t, cn, rn;
    w = 3 + k; t = w - 1;
    rn = ((((r >> 1) ^ (c >> (t - 1))) & 1) << 2) | (v << 1) | ((c >> t) & 1);
    cn = ((c << 1) & ((1 << w) - 1)) | (((r >> 2) ^ (c >> t)) & 1);
    it = (it + (1 << (9 - k)) - 1) % (1 << (9 - k));
    c = cn; r = rn;
  endtask

  function automatic int addr_of(int k, int it, int c);
    return ((it << (3 + k)) | c) & 12'hfff;
  endfunction

  task automatic fill_mem();
    for (int a = 0; a < 4096; a++) mem[a] = 8'(rnd());
  endtask

  // drive a run and compare address stream, bit stream and timing
  task automatic drive_and_check(string tag, int d, int n, bit poke);
    int cyc = 0, nrd = 0, nval = 0, aerr = 0, berr = 0, last_a = 0, last_e = 0;
    int tot = d + n - 1;
    int bad_b = 0, bad_e = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    forever begin
      if (mem_rd) begin
        if (nrd < tot && mem_addr != exp_addr[nrd]) begin
          aerr++; last_a = int'(mem_addr); last_e = int'(exp_addr[nrd]);
        end
        nrd++;
      end
      if (dec_valid) begin
        if (nval < n && dec_bit != exp_bit[d - 1 + nval]) begin
          berr++; bad_b = int'(dec_bit); bad_e = int'(exp_bit[d - 1 + nval]);
        end
        nval++;
      end
      if (busy) cyc++;
      if (!busy) break;
      if (cyc > 4000) begin
        check({tag, " watchdog"}, cyc, 0);
        break;
      end
      if (poke && cyc == 5) begin
        start = 1; start_addr = ~start_addr; start_row = ~start_row;
      end else start = 0;
      @(negedge clk);
    end
    start = 0;
    check({tag, " R6 busy cycles"}, cyc, 2 * tot);
    check({tag, " R6 read strobes"}, nrd, tot);
    if (aerr != 0) $display("  %s address mismatch act=%0h exp=%0h", tag, last_a, last_e);
    check({tag, " R2/R5 address errors"}, aerr, 0);
    check({tag, " R8 strobe count"}, nval, n);
    if (berr != 0) $display("  %s bit act=%0d exp=%0d", tag, bad_b, bad_e);
    check({tag, " R7/R10 bit errors"}, berr, 0);
  endtask

  task automatic run_chain(string tag, int k, int it0, int c0, int r0, int d, int n, bit poke);
    int it = it0, c = c0, r = r0, v;
    fill_mem();
    for (int j = 0; j < d + n - 1; j++) begin
      exp_addr[j] = 12'(addr_of(k, it, c));
      exp_bit[j]  = 1'(r & 1);
      v = rnd() & 1;
      mem[addr_of(k, it, c)][r] = 1'(v);
      walk(k, it, c, r, v);
    end
    cfg_k = 2'(k); start_addr = 12'(addr_of(k, it0, c0)); start_row = 3'(r0);
    depth = CNT_W'(d); nout = CNT_W'(n);
    drive_and_check(tag, d, n, poke);
  endtask

  task automatic test_reset();
    check("R1 busy after reset", int'(busy), 0);
    check("R1 mem_rd after reset", int'(mem_rd), 0);
    check("R1 dec_valid after reset", int'(dec_valid), 0);
  endtask

  // R3 worked example: R=101 C=100 V=1 -> R=011 C=000
  task automatic test_example();
    fill_mem();
    mem[addr_of(0, 20, 4)][5] = 1'b1;
    exp_addr[0] = 12'(addr_of(0, 20, 4)); exp_bit[0] = 1'b1;
    exp_addr[1] = 12'(addr_of(0, 19, 0)); exp_bit[1] = 1'b1;
    cfg_k = 0; start_addr = 12'(addr_of(0, 20, 4)); start_row = 3'b101;
    depth = 1; nout = 2;
    drive_and_check("R3 example", 1, 2, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_example();
    run_chain("R7 k7 d35 n16", 0, 300, 5, 3, 35, 16, 1'b0);
    run_chain("R4 k8", 1, 200, 13, 6, 40, 8, 1'b0);
    run_chain("R4 k9", 2, 90, 27, 1, 20, 10, 1'b0);
    run_chain("R5 k10 wrap R9 restart", 3, 2, 45, 4, 6, 4, 1'b1);
    run_chain("R6 d1 n1", 0, 0, 7, 7, 1, 1, 1'b0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule